// File: doc/BRIEF.md
# TDM Backplane Frame Aligner

The block recovers frame timing from a serial time-division backplane running on an 8.192 MHz reference clock. An 8 kHz frame pulse marks the start of every 125 µs frame. Each frame therefore spans 1024 clock cycles. The pulse is sampled on the falling clock edge. A configuration input sets whether the pulse is active low or active high. At every detected boundary the block emits a one-cycle frame-start strobe and restarts its cycle count.

The cycle count is turned into a channel number and a bit position for one of two stream rates. At 16.384 Mb/s a frame holds 256 eight-bit channels, and each clock cycle carries two bits. At 32.768 Mb/s a frame holds 512 channels, and each clock cycle carries four bits. Bits go out most significant first.

The block also checks the spacing of the pulses. It declares lock after two boundaries exactly one frame apart. It drops lock and raises a one-cycle error pulse in two cases: a boundary arrives early or late, or a whole frame passes with no boundary. After a misplaced boundary it realigns on that boundary at once.

Top module: `tdm_frame_aligner`

## Requirements
- R1: A boundary is the falling clock edge at which `fp_in` is at its active level. The active level is low when `fp_pol`=0 and high when `fp_pol`=1. An input held at the inactive level never produces a boundary.
- R2: `frame_start` is high for exactly the cycle after each boundary sample. In that cycle `chan`=0 and `bitpos`=7.
- R3: With `rate_sel`=0 (256 channels), at cycle n after a boundary, `chan` = n/4 and `bitpos` = 7 - 2*(n mod 4). `bitpos` is the highest bit carried in that cycle.
- R4: With `rate_sel`=1 (512 channels), at cycle n after a boundary, `chan` = n/2 and `bitpos` = 7 - 4*(n mod 2).
- R5: `locked` rises on a boundary that comes exactly 1024 cycles after the previous boundary, and stays high while boundaries keep that spacing.
- R6: A boundary at any cycle count other than 1023 clears `locked`, raises `err` for one cycle, and restarts the count from that boundary.
- R7: Once aligned, if count 1023 passes with no boundary, the block clears `locked`, raises `err` for one cycle and wraps the count to 0.
- R8: While unaligned (after reset or after a missing boundary), a frame without a boundary raises no `err`. The first boundary in this state does not set `locked`.
- R9: While `rst_n` is low, `frame_start`, `locked` and `err` are 0, `chan` is 0 and `bitpos` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.192 MHz reference clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | 8 kHz frame pulse |
| fp_pol | input | 1 | Pulse polarity: 0 = active low, 1 = active high |
| rate_sel | input | 1 | Stream rate: 0 = 16.384 Mb/s, 1 = 32.768 Mb/s |
| frame_start | output | 1 | One-cycle strobe after a detected boundary |
| chan | output | 10 | Current channel number |
| bitpos | output | 3 | Highest bit index carried in the current cycle |
| locked | output | 1 | Frame timing confirmed |
| err | output | 1 | One-cycle pulse on a misplaced or missing boundary |

## Verification
The bench builds the block with its default frame length of 1024 cycles. With that length, full frames at the real backplane timing can be run directly. This covers both the last-channel wrap (channel 255 or 511) and the exact 1023-count edge that decides between locking, realigning and timing out. Using the real length means the lock and timeout thresholds are tested at the true frame period rather than at a reduced size.

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner #(
  parameter int FRAME_CYCLES = 1024,
  localparam int CW = $clog2(FRAME_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_in,
  input  logic          fp_pol,
  input  logic          rate_sel,
  output logic          frame_start,
  output logic [CW-1:0] chan,
  output logic [2:0]    bitpos,
  output logic          locked,
  output logic          err
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  logic [CW-1:0] cyc;
  logic          synced;

  wire hit  = (fp_in == fp_pol);
  wire last = (cyc == LAST);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc         <= '0;
      synced      <= 1'b0;
      locked      <= 1'b0;
      err         <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= hit;
      err         <= 1'b0;
      if (hit) begin
        cyc    <= '0;
        synced <= 1'b1;
        locked <= synced && last;
        err    <= synced && !last;
      end else begin
        cyc <= last ? '0 : cyc + 1'b1;
        if (last && synced) begin
          synced <= 1'b0;
          locked <= 1'b0;
          err    <= 1'b1;
        end
      end
    end
  end

  assign chan   = rate_sel ? (cyc >> 1) : (cyc >> 2);
  assign bitpos = rate_sel ? (cyc[0] ? 3'd3 : 3'd7)
                           : 3'd7 - {cyc[1:0], 1'b0};

endmodule

module tdm_frame_aligner_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rate_sel,
  input logic          frame_start,
  input logic [CW-1:0] chan,
  input logic [2:0]    bitpos,
  input logic          locked,
  input logic          err
);

  // R2
  start_at_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
    frame_start |-> (chan == '0 && bitpos == 3'd7));

  // R5
  lock_on_boundary_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(locked) |-> frame_start);

  // R6
  err_unlocks_chk: assert property (@(negedge clk) disable iff (!rst_n)
    err |-> !locked);

  // R7
  err_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    err |=> !err);

  // R3
  slow_bitpos_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !rate_sel |-> bitpos[0]);

  // R4
  fast_bitpos_chk: assert property (@(negedge clk) disable iff (!rst_n)
    rate_sel |-> (bitpos == 3'd7 || bitpos == 3'd3));

endmodule

bind tdm_frame_aligner tdm_frame_aligner_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .frame_start(frame_start),
  .chan(chan), .bitpos(bitpos), .locked(locked), .err(err)
);

// File: tb/tdm_frame_aligner_tb.sv
`timescale 1ns/1ps
module tdm_frame_aligner_tb;
  localparam int CLK_PERIOD = 122;
  localparam int FRAME = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp_in = 1'b1;
  logic       fp_pol = 1'b0;
  logic       rate_sel = 1'b0;
  logic       frame_start, locked, err;
  logic [9:0] chan;
  logic [2:0] bitpos;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  tdm_frame_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fp_pol(fp_pol),
    .rate_sel(rate_sel), .frame_start(frame_start), .chan(chan),
    .bitpos(bitpos), .locked(locked), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse();
    fp_in = fp_pol;
    step();
    fp_in = ~fp_pol;
  endtask

  task automatic idle(int n, output int n_err, output int n_start);
    n_err = 0; n_start = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (err) n_err++;
      if (frame_start) n_start++;
    end
  endtask

  task automatic t_reset();
    step();
    check("R9 frame_start", frame_start, 0);
    check("R9 locked", locked, 0);
    check("R9 err", err, 0);
    check("R9 chan", chan, 0);
    check("R9 bitpos", bitpos, 7);
    rst_n = 1'b1;
  endtask

  task automatic t_unsynced();
    int ne, ns;
    idle(1500, ne, ns);
    check("R8 no err while unaligned", ne, 0);
    check("R1 inactive level gives no boundary", ns, 0);
    pulse();
    check("R1 active-low boundary", frame_start, 1);
    check("R8 first boundary no lock", locked, 0);
    check("R2 chan zero", chan, 0);
    check("R2 bitpos seven", bitpos, 7);
    step();
    check("R2 strobe one cycle", frame_start, 0);
  endtask

  task automatic t_rate16();
    for (int k = 2; k <= FRAME - 1; k++) begin
      step();
      if (k == 3) begin
        check("R3 chan n=3", chan, 0);
        check("R3 bitpos n=3", bitpos, 1);
      end
      if (k == 4) begin
        check("R3 chan n=4", chan, 1);
        check("R3 bitpos n=4", bitpos, 7);
      end
      if (k == 6) check("R3 bitpos n=6", bitpos, 3);
      if (k == FRAME - 1) begin
        check("R3 chan last", chan, 255);
        check("R3 bitpos last", bitpos, 1);
      end
    end
    pulse();
    check("R5 lock after exact spacing", locked, 1);
    check("R5 no err", err, 0);
    check("R2 strobe", frame_start, 1);
  endtask

  task automatic t_rate32();
    rate_sel = 1'b1;
    check("R4 bitpos n=0", bitpos, 7);
    for (int k = 1; k <= FRAME - 1; k++) begin
      step();
      if (k == 1) begin
        check("R4 chan n=1", chan, 0);
        check("R4 bitpos n=1", bitpos, 3);
      end
      if (k == 2) begin
        check("R4 chan n=2", chan, 1);
        check("R4 bitpos n=2", bitpos, 7);
      end
      if (k == FRAME - 1) begin
        check("R4 chan last", chan, 511);
        check("R4 bitpos last", bitpos, 3);
      end
    end
    pulse();
    check("R5 lock held", locked, 1);
    rate_sel = 1'b0;
  endtask

  task automatic t_early();
    for (int k = 1; k <= 500; k++) step();
    pulse();
    check("R6 early boundary err", err, 1);
    check("R6 early boundary unlock", locked, 0);
    check("R6 realign strobe", frame_start, 1);
    check("R6 realign chan", chan, 0);
    step();
    check("R6 err one cycle", err, 0);
    for (int k = 2; k <= FRAME - 1; k++) step();
    pulse();
    check("R6 relock on realigned frame", locked, 1);
  endtask

  task automatic t_missing();
    int ne, ns;
    for (int k = 1; k <= FRAME - 1; k++) step();
    check("R7 still locked at 1023", locked, 1);
    step();
    check("R7 missing boundary err", err, 1);
    check("R7 missing boundary unlock", locked, 0);
    check("R7 count wrapped", chan, 0);
    check("R7 no strobe", frame_start, 0);
    idle(1100, ne, ns);
    check("R8 no repeated err", ne, 0);
    pulse();
    check("R8 first boundary after miss no lock", locked, 0);
    check("R8 no err on resync", err, 0);
    for (int k = 1; k <= FRAME - 1; k++) step();
    pulse();
    check("R5 relock after miss", locked, 1);
  endtask

  task automatic t_polarity();
    int ne, ns;
    fp_pol = 1'b1;
    fp_in  = 1'b0;
    idle(1100, ne, ns);
    check("R1 low level ignored when active high", ns, 0);
    pulse();
    check("R1 active-high boundary", frame_start, 1);
    for (int k = 1; k <= FRAME - 1; k++) step();
    pulse();
    check("R1 active-high lock", locked, 1);
    check("R1 active-high strobe", frame_start, 1);
  endtask

  initial begin
    t_reset();
    t_unsynced();
    t_rate16();
    t_rate32();
    t_early();
    t_missing();
    t_polarity();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule